// File: doc/BRIEF.md
# CAN identifier acceptance filter

This block decides whether a received CAN identifier is kept or dropped. It holds a set of programmable acceptance code bytes and a matching set of mask bytes. The receive path presents the four identifier bytes together with a one-cycle valid strobe. One clock later the block raises an accept flag and reports the index of the filter that matched.

The same code and mask storage can be used in two ways, chosen by a mode input. In wide mode it forms two 32-bit filters. In narrow mode it forms four 16-bit filters. A mask bit of one removes that bit from the comparison.

Software reaches the storage through a byte-wide register port. Reads are allowed at any time. Writes take effect only while both the initialization request and its acknowledge are high. This keeps the filter contents from changing while traffic is being filtered.

Top module: `can_id_filter`

## Requirements
- R1: After reset every code and mask byte reads as 0x00, and `accept` and `hit_idx` are 0.
- R2: Register addresses 0–7 read code bytes 0–7, and addresses 8–15 read mask bytes 0–7. Addresses 16–31 read as 0x00, and a write to them changes no stored byte.
- R3: A write is stored only when `init_req` and `init_ack` are both 1 at the clock edge. At any other time a write leaves every stored byte unchanged.
- R4: For each compared bit, a mask bit of 0 requires the code bit to equal the identifier bit. A mask bit of 1 excludes that bit from the comparison. A filter matches when every unmasked bit agrees.
- R5: Identifier byte k is carried on `id_data[31-8k -: 8]`. With `narrow_mode` = 0, filter 0 compares code/mask bytes 0–3 and filter 1 compares bytes 4–7, each against identifier bytes 0–3 in the same order.
- R6: With `narrow_mode` = 1, filters 0–3 compare the byte pairs (0,1), (2,3), (4,5) and (6,7) against identifier bytes 0 and 1. Identifier bytes 2 and 3 have no effect.
- R7: `accept` and `hit_idx` update on the clock edge that samples `id_valid` = 1. `accept` is 1 exactly when some filter matched at that edge. `hit_idx` is the lowest matching filter index, and it is 0 whenever `accept` is 0. When `id_valid` is 0, `accept` is 0 on the next cycle.
- R8: Standard identifiers can be filtered by setting the low three mask bits of byte 1 of a filter to 1. Identifier byte 1 may then differ from the code in bits 2:0 and still be accepted.
- R9: In wide mode `hit_idx` is never 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| narrow_mode | input | 1 | 0: two 32-bit filters, 1: four 16-bit filters |
| id_valid | input | 1 | Identifier present strobe |
| id_data | input | 32 | Identifier bytes 0–3, byte 0 in the top bits |
| accept | output | 1 | Identifier accepted, one cycle after strobe |
| hit_idx | output | 2 | Lowest matching filter index |

## Verification
The bench uses the default parameters: two banks of four bytes and a 5-bit address. With these values the register map has sixteen unused addresses, so unmapped reads and aliased writes can be exercised. Both wide filters and all four narrow filters exist, so lowest-index priority, wide-mode index limits and the narrow mode's neglect of identifier bytes 2 and 3 can all be observed at the ports.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    // Filter arrangement selected by the mode input
    typedef enum logic {
        FILT_WIDE   = 1'b0,
        FILT_NARROW = 1'b1
    } filt_mode_e;

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs #(
    parameter int NUM_BYTES = 8,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_open,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [BYTE_W-1:0]                wdata,
    output logic [BYTE_W-1:0]                rdata,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0] code,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0] mask
);

    localparam int SEL_W = $clog2(NUM_BYTES);
    localparam logic [ADDR_W-1:0] CODE_END = ADDR_W'(NUM_BYTES);
    localparam logic [ADDR_W-1:0] MASK_END = ADDR_W'(2 * NUM_BYTES);

    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0] code;
        logic [NUM_BYTES-1:0][BYTE_W-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [SEL_W-1:0] sel;

    assign sel = addr[SEL_W-1:0];

    always_comb begin
        regs_d = regs_q;
        if (wr && wr_open) begin
            if (addr < CODE_END) begin
                regs_d.code[sel] = wdata;
            end else if (addr < MASK_END) begin
                regs_d.mask[sel] = wdata;
            end
        end
    end

    always_comb begin
        if (addr < CODE_END) begin
            rdata = regs_q.code[sel];
        end else if (addr < MASK_END) begin
            rdata = regs_q.mask[sel];
        end else begin
            rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign code = regs_q.code;
    assign mask = regs_q.mask;

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
    import can_filt_pkg::*;
#(
    parameter int NUM_BYTES    = 8,
    parameter int BYTE_W       = 8,
    parameter int ID_BYTES     = 4,
    parameter int NARROW_BYTES = 2
) (
    input  logic [NUM_BYTES-1:0][BYTE_W-1:0] code,
    input  logic [NUM_BYTES-1:0][BYTE_W-1:0] mask,
    input  logic [ID_BYTES-1:0][BYTE_W-1:0]  id,
    input  filt_mode_e                       mode,
    output logic [NUM_BYTES/NARROW_BYTES-1:0] hits
);

    localparam int NUM_WIDE   = NUM_BYTES / ID_BYTES;
    localparam int NUM_NARROW = NUM_BYTES / NARROW_BYTES;

    logic [NUM_BYTES-1:0] wide_ok;
    logic [NUM_BYTES-1:0] narrow_ok;

    // Per-byte agreement on all unmasked bits, against the identifier byte
    // each arrangement pairs with this storage byte.
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        assign wide_ok[k]   = ~|((code[k] ^ id[k % ID_BYTES]) & ~mask[k]);
        assign narrow_ok[k] = ~|((code[k] ^ id[k % NARROW_BYTES]) & ~mask[k]);
    end

    for (genvar f = 0; f < NUM_NARROW; f++) begin : g_filt
        logic n_hit;
        logic w_hit;
        assign n_hit = &narrow_ok[f*NARROW_BYTES +: NARROW_BYTES];
        if (f < NUM_WIDE) begin : g_wide
            assign w_hit = &wide_ok[f*ID_BYTES +: ID_BYTES];
        end else begin : g_none
            assign w_hit = 1'b0;
        end
        assign hits[f] = (mode == FILT_NARROW) ? n_hit : w_hit;
    end

endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 4,
    parameter int ADDR_W     = 5,
    parameter int IDX_W      = $clog2(NUM_BANKS * 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         init_req,
    input  logic                         init_ack,
    input  logic                         reg_wr,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [BYTE_W-1:0]            reg_wdata,
    output logic [BYTE_W-1:0]            reg_rdata,
    input  logic                         narrow_mode,
    input  logic                         id_valid,
    input  logic [BANK_BYTES*BYTE_W-1:0] id_data,
    output logic                         accept,
    output logic [IDX_W-1:0]             hit_idx
);

    localparam int NUM_BYTES    = NUM_BANKS * BANK_BYTES;
    localparam int ID_BYTES     = BANK_BYTES;
    localparam int NARROW_BYTES = BANK_BYTES / 2;
    localparam int NUM_NARROW   = NUM_BYTES / NARROW_BYTES;

    typedef struct packed {
        logic             accept;
        logic [IDX_W-1:0] idx;
    } out_t;

    logic [NUM_BYTES-1:0][BYTE_W-1:0] code_w;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] mask_w;
    logic [ID_BYTES-1:0][BYTE_W-1:0]  id_arr;
    logic [NUM_NARROW-1:0]            hits;
    logic                             any_hit;
    logic [IDX_W-1:0]                 first_idx;
    filt_mode_e                       mode;
    out_t                             out_d, out_q;

    assign mode = narrow_mode ? FILT_NARROW : FILT_WIDE;

    // Byte 0 of the identifier travels in the top bits of the bus
    for (genvar k = 0; k < ID_BYTES; k++) begin : g_id
        assign id_arr[k] = id_data[(ID_BYTES-1-k)*BYTE_W +: BYTE_W];
    end

    can_filt_regs #(
        .NUM_BYTES (NUM_BYTES),
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_open (init_req && init_ack),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .code    (code_w),
        .mask    (mask_w)
    );

    can_filt_match #(
        .NUM_BYTES    (NUM_BYTES),
        .BYTE_W       (BYTE_W),
        .ID_BYTES     (ID_BYTES),
        .NARROW_BYTES (NARROW_BYTES)
    ) i_match (
        .code (code_w),
        .mask (mask_w),
        .id   (id_arr),
        .mode (mode),
        .hits (hits)
    );

    can_filt_prio #(
        .N     (NUM_NARROW),
        .IDX_W (IDX_W)
    ) i_prio (
        .hits (hits),
        .any  (any_hit),
        .idx  (first_idx)
    );

    always_comb begin
        out_d.accept = id_valid && any_hit;
        out_d.idx    = out_d.accept ? first_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign accept  = out_q.accept;
    assign hit_idx = out_q.idx;

endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
    parameter int NUM_BYTES = 8,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 5,
    parameter int IDX_W     = 2,
    parameter int NUM_WIDE  = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             init_req,
    input logic                             init_ack,
    input logic                             reg_wr,
    input logic [ADDR_W-1:0]                reg_addr,
    input logic [BYTE_W-1:0]                reg_rdata,
    input logic                             narrow_mode,
    input logic                             id_valid,
    input logic                             accept,
    input logic [IDX_W-1:0]                 hit_idx,
    input logic [NUM_BYTES-1:0][BYTE_W-1:0] code_q,
    input logic [NUM_BYTES-1:0][BYTE_W-1:0] mask_q
);

    localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(2 * NUM_BYTES);

    // R7
    accept_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(id_valid));

    // R7
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (hit_idx == '0));

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !(init_req && init_ack)) |=> ($stable(code_q) && $stable(mask_q)));

    // R2
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= MAP_END) |=> ($stable(code_q) && $stable(mask_q)));

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= MAP_END) |-> (reg_rdata == '0));

    // R9
    wide_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !$past(narrow_mode)) |-> (hit_idx < IDX_W'(NUM_WIDE)));

endmodule

bind can_id_filter can_filt_chk #(
    .NUM_BYTES (NUM_BANKS * BANK_BYTES),
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .NUM_WIDE  (NUM_BANKS)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req    (init_req),
    .init_ack    (init_ack),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .narrow_mode (narrow_mode),
    .id_valid    (id_valid),
    .accept      (accept),
    .hit_idx     (hit_idx),
    .code_q      (code_w),
    .mask_q      (mask_w)
);

// File: tb/test_can_id_filter.sv
module test_can_id_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0;
    logic        init_ack = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        narrow_mode = 1'b0;
    logic        id_valid = 1'b0;
    logic [31:0] id_data = '0;
    logic        accept;
    logic [1:0]  hit_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_id_filter i_can_id_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_req    (init_req),
        .init_ack    (init_ack),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .narrow_mode (narrow_mode),
        .id_valid    (id_valid),
        .id_data     (id_data),
        .accept      (accept),
        .hit_idx     (hit_idx)
    );

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check_val(req, reg_rdata, exp);
    endtask

    task automatic id_check(input string req, input logic [31:0] id,
                            input logic exp_acc, input logic [1:0] exp_idx);
        @(negedge clk);
        id_data = id;
        id_valid = 1'b1;
        @(negedge clk);
        id_valid = 1'b0;
        check_val({req, " accept"}, accept, exp_acc);
        check_val({req, " idx"}, hit_idx, exp_idx);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 16; a++) rd_check("R1 reset byte", 5'(a), 8'h00);
        check_val("R1 reset accept", accept, 0);
        check_val("R1 reset idx", hit_idx, 0);
    endtask

    task automatic t_locked;
        init_req = 1'b1; init_ack = 1'b0;
        wr_reg(5'd0, 8'hAA);
        rd_check("R3 locked ack low", 5'd0, 8'h00);
        init_req = 1'b0; init_ack = 1'b1;
        wr_reg(5'd9, 8'h55);
        rd_check("R3 locked req low", 5'd9, 8'h00);
    endtask

    task automatic t_program_wide;
        init_req = 1'b1; init_ack = 1'b1;
        wr_reg(5'd0, 8'h12); wr_reg(5'd1, 8'h34); wr_reg(5'd2, 8'h56); wr_reg(5'd3, 8'h78);
        wr_reg(5'd4, 8'hAB); wr_reg(5'd5, 8'hCD); wr_reg(5'd6, 8'hEF); wr_reg(5'd7, 8'h01);
        rd_check("R3 open write code", 5'd2, 8'h56);
        wr_reg(5'd8, 8'h3C);
        rd_check("R2 mask readback", 5'd8, 8'h3C);
        rd_check("R2 code untouched by mask", 5'd0, 8'h12);
        wr_reg(5'd8, 8'h00);
    endtask

    task automatic t_unmapped;
        wr_reg(5'd20, 8'hEE);
        rd_check("R2 unmapped read", 5'd20, 8'h00);
        rd_check("R2 alias code byte", 5'd4, 8'hAB);
        wr_reg(5'd28, 8'hEE);
        rd_check("R2 alias mask byte", 5'd12, 8'h00);
    endtask

    task automatic t_wide_match;
        narrow_mode = 1'b0;
        id_check("R5 filter0 exact", 32'h12345678, 1'b1, 2'd0);
        id_check("R5 filter1 exact", 32'hABCDEF01, 1'b1, 2'd1);
        id_check("R4 one bit off", 32'h12345679, 1'b0, 2'd0);
    endtask

    task automatic t_mask;
        wr_reg(5'd11, 8'h0F);
        id_check("R4 masked nibble", 32'h12345670, 1'b1, 2'd0);
        id_check("R4 unmasked nibble", 32'h12345688, 1'b0, 2'd0);
        wr_reg(5'd11, 8'h00);
    endtask

    task automatic t_standard;
        id_check("R8 before mask", 32'h12335678, 1'b0, 2'd0);
        wr_reg(5'd9, 8'h07);
        id_check("R8 low three ignored", 32'h12335678, 1'b1, 2'd0);
        id_check("R8 bit3 still compared", 32'h123C5678, 1'b0, 2'd0);
        wr_reg(5'd9, 8'h00);
    endtask

    task automatic t_priority;
        for (int a = 12; a < 16; a++) wr_reg(5'(a), 8'hFF);
        id_check("R7 both hit lowest wins", 32'h12345678, 1'b1, 2'd0);
        id_check("R7 only filter1", 32'h00000000, 1'b1, 2'd1);
        @(negedge clk);
        id_data = 32'h12345678;
        @(negedge clk);
        check_val("R7 no strobe", accept, 0);
        for (int a = 12; a < 16; a++) wr_reg(5'(a), 8'h00);
    endtask

    task automatic t_narrow;
        narrow_mode = 1'b1;
        id_check("R6 pair0 bytes2-3 ignored", 32'h1234FFFF, 1'b1, 2'd0);
        id_check("R6 pair1", 32'h56780000, 1'b1, 2'd1);
        id_check("R6 pair2", 32'hABCD1234, 1'b1, 2'd2);
        id_check("R6 pair3", 32'hEF019999, 1'b1, 2'd3);
        id_check("R6 no pair", 32'h00001234, 1'b0, 2'd0);
        narrow_mode = 1'b0;
        id_check("R9 wide rejects pair3", 32'hEF019999, 1'b0, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_program_wide();
        t_unmapped();
        t_wide_match();
        t_mask();
        t_standard();
        t_priority();
        t_narrow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule